// File: doc/BRIEF.md
# Dual-Input Up/Down Presettable Counter

This block is a small binary counter whose direction is chosen by which of two count inputs makes a rising edge. An edge on the up input adds one, and an edge on the down input subtracts one. Both count inputs idle high. Each count input passes through a two-flop synchronizer and a rising-edge detector, all clocked by one system clock. The count register changes on a system clock edge, and every output bit changes on that same edge.

A level-sensitive clear input and an active-low load input override counting. Clear beats load. Two active-low cascade outputs drive a following stage. The carry output is low while the count is at its maximum and the synchronized up level is low. The borrow output is low while the count is zero and the synchronized down level is low. Each one therefore gives a rising edge when the matching count input returns high, and the next stage can use that edge as its own count input.

Top module: `updn_dual_counter`

## Requirements
- R1: While the synchronized down level is high, a rising edge on `up_i` adds one to `q_o`. The new value appears on the third system clock edge after the rising edge of `up_i`, and not earlier.
- R2: While the synchronized up level is high, a rising edge on `dn_i` subtracts one from `q_o`. It has the same latency as R1.
- R3: The count wraps modulo 2^W. Incrementing from all ones gives 0, and decrementing from 0 gives all ones (15 for W=4).
- R4: While `clr_i` is high, the next clock edge sets `q_o` to 0. This holds whatever `load_ni`, `din_i` and the count inputs are doing.
- R5: While `clr_i` is low and `load_ni` is low, each clock edge copies `din_i` into `q_o`. Count edges seen during load are ignored.
- R6: `carry_no` is low exactly when `q_o` is all ones and the synchronized up level is low. In every other case it is high.
- R7: `borrow_no` is low exactly when `q_o` is 0 and the synchronized down level is low. In every other case it is high.
- R8: The count holds in two cases: when rising edges on both count inputs are detected in the same cycle, and when an edge arrives while the other count input's synchronized level is low.
- R9: After `rst_ni` is low, `q_o` is 0. The synchronizers hold the idle-high level, so `carry_no` and `borrow_no` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| up_i | input | 1 | Count-up input, idles high, acts on its rising edge |
| dn_i | input | 1 | Count-down input, idles high, acts on its rising edge |
| clr_i | input | 1 | Clear, active high, highest priority |
| load_ni | input | 1 | Parallel load, active low |
| din_i | input | W | Preset data |
| q_o | output | W | Count value |
| carry_no | output | 1 | Active-low terminal-count output for the up direction |
| borrow_no | output | 1 | Active-low terminal-count output for the down direction |

## Verification
The hardest cases to reach are the hold conditions of R8. To reach them, both count inputs must be synchronized low at once, and then the edges must be released in a chosen order. The stimulus holds down low, pulses up while down stays low, and checks that the count is unchanged. It then releases down and expects exactly one decrement. For the simultaneous case, it drops both inputs together and raises them on the same clock, so that both edge detectors fire in one cycle.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_INC   = 3'd1,
    ACT_DEC   = 3'd2,
    ACT_LOAD  = 3'd3,
    ACT_CLEAR = 3'd4
  } udc_action_e;
endpackage

// File: rtl/udc_edge_sync.sv
module udc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[DEPTH-2:0], async_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/udc_action_dec.sv
module udc_action_dec
  import udc_pkg::*;
(
  input  logic        clr_i,
  input  logic        load_ni,
  input  logic        up_rise_i,
  input  logic        dn_rise_i,
  input  logic        up_lvl_i,
  input  logic        dn_lvl_i,
  output udc_action_e act_o
);
  logic go_up, go_dn;

  assign go_up = up_rise_i & dn_lvl_i & ~dn_rise_i;
  assign go_dn = dn_rise_i & up_lvl_i & ~up_rise_i;

  always_comb begin
    if (clr_i)         act_o = ACT_CLEAR;
    else if (!load_ni) act_o = ACT_LOAD;
    else if (go_up)    act_o = ACT_INC;
    else if (go_dn)    act_o = ACT_DEC;
    else               act_o = ACT_HOLD;
  end
endmodule

// File: rtl/udc_count_reg.sv
module udc_count_reg
  import udc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  udc_action_e act_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o
);
  function automatic logic [W-1:0] next_count(input udc_action_e a,
                                              input logic [W-1:0] cur,
                                              input logic [W-1:0] d);
    case (a)
      ACT_CLEAR: return '0;
      ACT_LOAD:  return d;
      ACT_INC:   return cur + W'(1);
      ACT_DEC:   return cur - W'(1);
      default:   return cur;
    endcase
  endfunction

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= next_count(act_i, cnt_q, din_i);
  end

  assign q_o = cnt_q;
endmodule

// File: rtl/udc_cascade.sv
module udc_cascade #(
  parameter int W = 4
) (
  input  logic [W-1:0] q_i,
  input  logic         up_lvl_i,
  input  logic         dn_lvl_i,
  output logic         carry_no,
  output logic         borrow_no
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic at_top(input logic [W-1:0] v);
    return v == TOP;
  endfunction

  function automatic logic at_zero(input logic [W-1:0] v);
    return v == '0;
  endfunction

  assign carry_no  = ~(at_top(q_i)  & ~up_lvl_i);
  assign borrow_no = ~(at_zero(q_i) & ~dn_lvl_i);
endmodule

// File: rtl/updn_dual_counter.sv
module updn_dual_counter
  import udc_pkg::*;
#(
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         clr_i,
  input  logic         load_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o,
  output logic         carry_no,
  output logic         borrow_no
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in, lvl, rise;
  logic           up_lvl, dn_lvl, up_rise, dn_rise;
  udc_action_e    act;

  assign raw_in = {dn_i, up_i};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    udc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (raw_in[c]),
      .level_o (lvl[c]),
      .rise_o  (rise[c])
    );
  end

  assign up_lvl  = lvl[0];
  assign dn_lvl  = lvl[1];
  assign up_rise = rise[0];
  assign dn_rise = rise[1];

  udc_action_dec i_dec (
    .clr_i     (clr_i),
    .load_ni   (load_ni),
    .up_rise_i (up_rise),
    .dn_rise_i (dn_rise),
    .up_lvl_i  (up_lvl),
    .dn_lvl_i  (dn_lvl),
    .act_o     (act)
  );

  udc_count_reg #(.W(W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .din_i  (din_i),
    .q_o    (q_o)
  );

  udc_cascade #(.W(W)) i_casc (
    .q_i       (q_o),
    .up_lvl_i  (up_lvl),
    .dn_lvl_i  (dn_lvl),
    .carry_no  (carry_no),
    .borrow_no (borrow_no)
  );
endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         load_ni,
  input logic [W-1:0] din_i,
  input logic [W-1:0] q_o,
  input logic         carry_no,
  input logic         borrow_no,
  input logic         up_lvl,
  input logic         dn_lvl,
  input logic         up_rise,
  input logic         dn_rise
);
  localparam logic [W-1:0] TOP = '1;

  logic counting;
  assign counting = !clr_i && load_ni;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> q_o == '0); // R4

  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_ni) |=> q_o == $past(din_i)); // R5

  AST_INC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && up_rise && !dn_rise && dn_lvl) |=> q_o == W'($past(q_o) + 1'b1)); // R1

  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && dn_rise && !up_rise && up_lvl) |=> q_o == W'($past(q_o) - 1'b1)); // R2

  AST_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && up_rise && !dn_rise && dn_lvl && q_o == TOP) |=> q_o == '0); // R3

  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && up_rise && dn_rise) |=> $stable(q_o)); // R8

  AST_CARRY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (q_o == TOP && !up_lvl)); // R6

  AST_BORROW_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> (q_o == '0 && !dn_lvl)); // R7
endmodule

bind updn_dual_counter udc_checker #(.W(W)) i_udc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .load_ni   (load_ni),
  .din_i     (din_i),
  .q_o       (q_o),
  .carry_no  (carry_no),
  .borrow_no (borrow_no),
  .up_lvl    (up_lvl),
  .dn_lvl    (dn_lvl),
  .up_rise   (up_rise),
  .dn_rise   (dn_rise)
);

// File: tb/test_updn_dual_counter.sv
`timescale 1ns/1ps
module test_updn_dual_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up = 1'b1, dn = 1'b1, clr = 1'b0, load_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         carry_n, borrow_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  updn_dual_counter #(.W(W)) i_updn_dual_counter (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn), .clr_i(clr),
    .load_ni(load_n), .din_i(din), .q_o(q), .carry_no(carry_n), .borrow_no(borrow_n)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_value(input logic [W-1:0] v);
    @(negedge clk); load_n = 1'b0; din = v;
    @(negedge clk); load_n = 1'b1;
  endtask

  task automatic pulse_up();
    @(negedge clk); up = 1'b0; wait_n(3); up = 1'b1; wait_n(4);
  endtask

  task automatic pulse_dn();
    @(negedge clk); dn = 1'b0; wait_n(3); dn = 1'b1; wait_n(4);
  endtask

  task automatic t_reset();
    check("R9 count", q, 0);
    check("R9 carry", carry_n, 1);
    check("R9 borrow", borrow_n, 1);
  endtask

  task automatic t_load();
    load_value(4'd5);
    check("R5 load", q, 5);
    @(negedge clk); load_n = 1'b0; din = 4'd10;
    up = 1'b0; wait_n(3); up = 1'b1; wait_n(4);
    check("R5 count ignored during load", q, 10);
    load_n = 1'b1;
    load_value(4'd5);
  endtask

  task automatic t_up_latency();
    @(negedge clk); up = 1'b0; wait_n(3); up = 1'b1;
    wait_n(2);
    check("R1 not before third edge", q, 5);
    wait_n(1);
    check("R1 third edge", q, 6);
    wait_n(3);
    pulse_up(); pulse_up();
    check("R1 three increments", q, 8);
  endtask

  task automatic t_down();
    pulse_dn(); pulse_dn();
    check("R2 two decrements", q, 6);
  endtask

  task automatic t_wrap_and_cascade();
    load_value(4'd15);
    check("R6 carry high while up idle", carry_n, 1);
    @(negedge clk); up = 1'b0; wait_n(3);
    check("R6 carry low at max", carry_n, 0);
    check("R7 borrow high at max", borrow_n, 1);
    up = 1'b1; wait_n(4);
    check("R3 wrap up", q, 0);
    check("R6 carry back high", carry_n, 1);
    @(negedge clk); dn = 1'b0; wait_n(3);
    check("R7 borrow low at zero", borrow_n, 0);
    check("R6 carry high at zero", carry_n, 1);
    dn = 1'b1; wait_n(4);
    check("R3 wrap down", q, 15);
    check("R7 borrow back high", borrow_n, 1);
    load_value(4'd3);
    @(negedge clk); dn = 1'b0; wait_n(3);
    check("R7 borrow high at nonzero", borrow_n, 1);
    dn = 1'b1; wait_n(4);
    check("R2 decrement from 3", q, 2);
  endtask

  task automatic t_holds();
    load_value(4'd7);
    @(negedge clk); up = 1'b0; dn = 1'b0; wait_n(3);
    up = 1'b1; dn = 1'b1; wait_n(4);
    check("R8 simultaneous edges hold", q, 7);
    @(negedge clk); dn = 1'b0; wait_n(3);
    up = 1'b0; wait_n(3); up = 1'b1; wait_n(4);
    check("R8 up edge with down low holds", q, 7);
    dn = 1'b1; wait_n(4);
    check("R2 released down decrements once", q, 6);
  endtask

  task automatic t_clear();
    load_value(4'd9);
    @(negedge clk); clr = 1'b1; load_n = 1'b0; din = 4'd12; up = 1'b0;
    wait_n(1);
    check("R4 clear beats load", q, 0);
    wait_n(2); up = 1'b1; wait_n(4);
    check("R4 clear beats count", q, 0);
    clr = 1'b0; load_n = 1'b1; wait_n(2);
    check("R4 stays zero after clear", q, 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_load();
    t_up_latency();
    t_down();
    t_wrap_and_cascade();
    t_holds();
    t_clear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule